// File: doc/BRIEF.md
# I2C Register Slave Interface

This block lets an external I2C master at up to 400 kbit/s read and write a bank of internal byte registers. SCL and SDA are sampled with the core clock through synchronizers, start and stop conditions and clock edges are found on the synchronized samples, and SDA is driven only through an open-drain enable (`sda_drive_low` high pulls the line low). The block answers only to its own 7-bit device address and never holds SCL low.

A write transaction carries the device address with a write direction bit, then one register index byte, then any number of data bytes, each placed on the internal register bus. A read transaction first sets the index with a short write, then issues a repeated start, the address with a read direction bit, and receives bytes until it answers one with a NACK. After power-up or wake-up, the block stays deaf to the bus for a programmable settling time.

The internal register bus is a strobe interface with no back-pressure, because the slave cannot stretch the clock. A write is a one-cycle `reg_wr_en` pulse with `reg_index` and `reg_wr_data` valid in that cycle. A read is a one-cycle `reg_rd_pulse`, and `reg_rd_data` must already be valid for `reg_index` in that same cycle. Clear-on-read registers may act on the pulse.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_drive_low`, `reg_wr_en` and `reg_rd_pulse` are all low.
- R2: The block ignores the bus while `wake` is low, and for `WAKE_CYCLES` clock cycles after `wake` rises: no acknowledge, no register access.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The first byte is seven address bits, MSB first, followed by a direction bit (0 is write, 1 is read). On an address equal to `DEV_ADDR`, the slave pulls SDA low for the ninth clock. On any other address it leaves SDA released until the next start.
- R4: In a write transaction, the byte after the address is the register index. The slave acknowledges it, and the index appears on `reg_index`.
- R5: Each data byte that follows the index gives exactly one single-cycle `reg_wr_en` pulse, with `reg_wr_data` equal to the byte and `reg_index` equal to the current index. The slave acknowledges each such byte.
- R6: Consecutive data bytes in one write go to consecutive indices, and the index wraps from 0xFF to 0x00.
- R7: After a repeated start and the address with the read bit, the slave acknowledges and then shifts out, MSB first, the byte at the current index. There is one `reg_rd_pulse` for each byte loaded, and read and write pulses never coincide.
- R8: In a read, each master ACK (SDA low on the ninth clock) advances the index by one and loads the next byte. A master NACK stops loading and releases SDA.
- R9: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | High when the device has left standby |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |
| reg_index | output | 8 | Current register index |
| reg_wr_data | output | 8 | Byte to write |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rd_data | input | 8 | Register contents at `reg_index`, valid in the same cycle |
| reg_rd_pulse | output | 1 | One-cycle read strobe, on each byte load |

## Verification
The assertions rely on a few properties of the inputs:
- The master changes SDA only while SCL is low, except for start and stop conditions.
- Each SCL phase lasts longer than the synchronizer latency.
- `reg_rd_data` is valid combinationally for the presented index.

The bench master keeps within these limits. It holds every quarter bit for six core cycles, moves SDA only a quarter bit after SCL has fallen, and models SDA as a wired-AND of its own drive and the slave's enable. Its register model answers reads combinationally from an array.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } xfer_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe;
  logic [PIPE_W-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  // Synchronizer stages plus one history stage, idle-high reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_q = scl_pipe[SYNC_STAGES];
  assign sda_q = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_wake_timer.sv
module i2c_wake_timer #(
  parameter int WAKE_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  output logic awake
);
  localparam int TW = $clog2(WAKE_CYCLES + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      awake <= 1'b0;
    end else if (!wake) begin
      cnt   <= '0;
      awake <= 1'b0;
    end else if (cnt == TW'(WAKE_CYCLES)) begin
      awake <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_sleep_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> !awake);
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_drive_low,
  output logic [REG_AW-1:0] reg_index,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_wr_en,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              reg_rd_pulse
);
  xfer_state_e       st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_q;
  logic              mack_q;
  logic              load_rd;
  logic              byte_done;

  assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));

  // A byte is fetched at the end of the read-address ACK or of a master ACK.
  assign load_rd = awake && scl_fall &&
                   ((st == ST_ADDR_ACK && rw_q) || (st == ST_RDATA_ACK && mack_q));
  assign reg_rd_pulse = load_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      bit_cnt       <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      rw_q          <= 1'b0;
      mack_q        <= 1'b0;
      sda_drive_low <= 1'b0;
      reg_index     <= '0;
      reg_wr_data   <= '0;
      reg_wr_en     <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      if (!awake) begin
        st            <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else if (start_det) begin
        st            <= ST_ADDR;
        bit_cnt       <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        st            <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (st == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                  rw_q          <= rx_sh[0];
                  sda_drive_low <= 1'b1;
                  st            <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_SUB) begin
                reg_index     <= rx_sh[REG_AW-1:0];
                sda_drive_low <= 1'b1;
                st            <= ST_SUB_ACK;
              end else begin
                reg_wr_data   <= rx_sh;
                reg_wr_en     <= 1'b1;
                sda_drive_low <= 1'b1;
                st            <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx_sh         <= reg_rd_data;
                sda_drive_low <= ~reg_rd_data[BYTE_W-1];
                st            <= ST_RDATA;
              end else begin
                sda_drive_low <= 1'b0;
                st            <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              st            <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              reg_index     <= reg_index + 1'b1;
              st            <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                bit_cnt       <= '0;
                sda_drive_low <= 1'b0;
                st            <= ST_RDATA_ACK;
              end else begin
                tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_drive_low <= ~tx_sh[BYTE_W-2];
                bit_cnt       <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s) reg_index <= reg_index + 1'b1;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sh         <= reg_rd_data;
                sda_drive_low <= ~reg_rd_data[BYTE_W-1];
                st            <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_pulse));
  p_rd_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_pulse |-> !scl_s);
  p_asleep_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (!sda_drive_low && !reg_wr_en));
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         WAKE_CYCLES = 100000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  output logic [REG_AW-1:0] reg_index,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_wr_en,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              reg_rd_pulse
);
  logic awake;
  logic scl_s;
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_det;
  logic stop_det;

  i2c_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .wake  (wake),
    .awake (awake)
  );

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .awake         (awake),
    .scl_s         (scl_s),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .reg_index     (reg_index),
    .reg_wr_data   (reg_wr_data),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_data   (reg_rd_data),
    .reg_rd_pulse  (reg_rd_pulse)
  );
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 2000;
  localparam int QTR = 6;
  localparam logic [6:0] DEV = 7'h4C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_drive_low;
  logic [7:0] reg_index;
  logic [7:0] reg_wr_data;
  logic reg_wr_en;
  logic [7:0] reg_rd_data;
  logic reg_rd_pulse;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int re_cnt = 0;
  int r9_bad = 0;
  bit done = 1'b0;
  logic oe_q = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] log_a [16];
  logic [7:0] log_d [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;
  assign reg_rd_data = mem[reg_index];

  i2c_reg_slave #(.DEV_ADDR(DEV), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .reg_index(reg_index),
    .reg_wr_data(reg_wr_data), .reg_wr_en(reg_wr_en),
    .reg_rd_data(reg_rd_data), .reg_rd_pulse(reg_rd_pulse)
  );

  // Register model and bus monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (reg_wr_en) begin
      mem[reg_index] <= reg_wr_data;
      log_a[wr_cnt % 16] <= reg_index;
      log_d[wr_cnt % 16] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rst_n && reg_rd_pulse) re_cnt <= re_cnt + 1;
    if (rst_n && sda_drive_low && !oe_q && scl_m) r9_bad <= r9_bad + 1;
    oe_q <= sda_drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    b = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack_n);
  endtask

  task automatic rbyte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(give_ack ? 1'b0 : 1'b1);
  endtask

  task automatic t_reset();
    chk(sda_drive_low == 1'b0, "R1 sda", int'(sda_drive_low), 0);
    chk(reg_wr_en == 1'b0, "R1 wr_en", int'(reg_wr_en), 0);
    chk(reg_rd_pulse == 1'b0, "R1 rd_pulse", int'(reg_rd_pulse), 0);
  endtask

  task automatic t_sleep();
    logic a;
    int w0 = wr_cnt;
    wake = 1'b1;
    i2c_start(); wbyte({DEV, 1'b0}, a);
    chk(a == 1'b1, "R2 no ack during settle", int'(a), 1);
    wbyte(8'h05, a); wbyte(8'h99, a);
    i2c_stop();
    chk(wr_cnt == w0, "R2 no write during settle", wr_cnt - w0, 0);
    repeat (WAKE + 20) @(negedge clk);
  endtask

  task automatic t_bad_addr();
    logic a;
    int w0 = wr_cnt;
    i2c_start(); wbyte({7'h4D, 1'b0}, a);
    chk(a == 1'b1, "R3 wrong address nack", int'(a), 1);
    wbyte(8'h01, a);
    chk(a == 1'b1, "R3 stays released", int'(a), 1);
    wbyte(8'h55, a);
    i2c_stop();
    chk(wr_cnt == w0, "R3 no write after mismatch", wr_cnt - w0, 0);
  endtask

  task automatic t_single_write();
    logic a0, a1, a2;
    int w0 = wr_cnt;
    i2c_start();
    wbyte({DEV, 1'b0}, a0); wbyte(8'h42, a1);
    chk(a0 == 1'b0, "R3 address ack", int'(a0), 0);
    chk(a1 == 1'b0, "R4 index ack", int'(a1), 0);
    chk(reg_index == 8'h42, "R4 index on bus", int'(reg_index), 8'h42);
    wbyte(8'h9C, a2);
    i2c_stop();
    chk(a2 == 1'b0, "R5 data ack", int'(a2), 0);
    chk(wr_cnt == w0 + 1, "R5 one write pulse", wr_cnt - w0, 1);
    chk(log_a[w0 % 16] == 8'h42, "R5 write index", int'(log_a[w0 % 16]), 8'h42);
    chk(log_d[w0 % 16] == 8'h9C, "R5 write data", int'(log_d[w0 % 16]), 8'h9C);
  endtask

  task automatic t_burst_write();
    logic a;
    logic [7:0] vals [3] = '{8'hA1, 8'hB2, 8'hC3};
    logic [7:0] idx [3] = '{8'hFE, 8'hFF, 8'h00};
    int w0 = wr_cnt;
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(8'hFE, a);
    for (int k = 0; k < 3; k++) wbyte(vals[k], a);
    i2c_stop();
    chk(wr_cnt == w0 + 3, "R6 burst count", wr_cnt - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(log_a[(w0 + k) % 16] == idx[k], "R6 burst index",
          int'(log_a[(w0 + k) % 16]), int'(idx[k]));
      chk(log_d[(w0 + k) % 16] == vals[k], "R6 burst data",
          int'(log_d[(w0 + k) % 16]), int'(vals[k]));
    end
  endtask

  task automatic read_seq(input logic [7:0] idx, input int n, input logic [7:0] exp [4],
                          input string tag);
    logic a;
    logic [7:0] v;
    int r0 = re_cnt;
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(idx, a);
    i2c_start(); wbyte({DEV, 1'b1}, a);
    chk(a == 1'b0, {tag, " read address ack"}, int'(a), 0);
    for (int k = 0; k < n; k++) begin
      rbyte(v, k != n - 1);
      chk(v == exp[k], {tag, " read data"}, int'(v), int'(exp[k]));
    end
    qwait();
    chk(sda_drive_low == 1'b0, "R8 released after nack", int'(sda_drive_low), 0);
    i2c_stop();
    chk(re_cnt == r0 + n, {tag, " read pulse count"}, re_cnt - r0, n);
  endtask

  task automatic t_single_read();
    logic [7:0] e [4];
    e = '{8'h73, 8'h0, 8'h0, 8'h0};
    read_seq(8'h10, 1, e, "R7");
    e = '{8'hC3, 8'h0, 8'h0, 8'h0};
    read_seq(8'h00, 1, e, "R7 written");
  endtask

  task automatic t_seq_read();
    logic [7:0] e [4];
    for (int k = 0; k < 4; k++) e[k] = 8'((32 + k) * 7 + 3);
    read_seq(8'h20, 4, e, "R8");
    e = '{8'hB2, 8'hC3, 8'h0, 8'h0};
    read_seq(8'hFF, 2, e, "R8 wrap");
  endtask

  task automatic t_wake_drop();
    logic a;
    wake = 1'b0;
    repeat (5) @(negedge clk);
    wake = 1'b1;
    i2c_start(); wbyte({DEV, 1'b0}, a);
    chk(a == 1'b1, "R2 ignored after wake drop", int'(a), 1);
    i2c_stop();
    repeat (WAKE + 20) @(negedge clk);
    i2c_start(); wbyte({DEV, 1'b0}, a);
    chk(a == 1'b0, "R2 ack once settled", int'(a), 0);
    i2c_stop();
  endtask

  task automatic t_drive_timing();
    chk(r9_bad == 0, "R9 drive start while SCL high", r9_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_sleep();
    t_bad_addr();
    t_single_write();
    t_burst_write();
    t_single_read();
    t_seq_read();
    t_wake_drop();
    t_drive_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule